// File: doc/BRIEF.md
# T1 Remote Alarm Indication Detector

This block watches a framed T1 receive stream for the far end's remote alarm indication (the yellow alarm) and keeps a level flag that follows it. A framer upstream does the alignment and hands over three kinds of strobe. The first marks bit 2 of each channel. The second marks each framing-bit position and carries the frame index within the superframe. The third marks each bit of the data link. The block itself never looks at raw line timing.

A two-bit mode input picks one of three rules, and each rule has its own hysteresis. Superframe bit-2 mode counts the zero bits in non-overlapping blocks of 256 channel samples. Superframe framing-bit mode requires two matching values in a row of the 12th framing bit. Extended-superframe mode looks for a repeating 16-bit alarm pattern in aligned data-link slots. The flag and a one-cycle change pulse are registered outputs. When the mode changes, the flag and every counter are cleared. While the framer reports that it is out of sync, every strobe is ignored.

Top module: `t1_rai_detect`

## Requirements
- R1: After a synchronous reset, `alarm` and `alarm_chg` are both 0.
- R2: In mode 0 (superframe bit 2), bit-2 samples form back-to-back blocks of 256. A block with at least 254 zero samples sets `alarm`.
- R3: In mode 0, a block with 253 or fewer zeros clears `alarm`. The flag can change only when a block completes, so after 255 samples of a block it still holds its earlier value.
- R4: In mode 1 (12th framing bit), `alarm` sets when the 12th framing bit is 1 on two consecutive superframes. A single 1 does not set it.
- R5: In mode 1, `alarm` clears when the 12th framing bit is 0 on two consecutive superframes. Alternating values leave the flag unchanged.
- R6: In mode 1, only framing strobes with `fb_idx` equal to 11 (frame index counted from 0) are used. Strobes at any other index have no effect.
- R7: In mode 2 (extended superframe), data-link bits are grouped into aligned 16-bit slots, with the first bit received as the MSB. `alarm` sets when 16 consecutive slots equal 16'h00FF. Fifteen matches are not enough, and the bit-reversed word 16'hFF00 never counts as a match.
- R8: In mode 2, `alarm` clears when 14 or fewer of the last 16 slots match. With 15 matches the flag holds.
- R9: While `in_sync` is 0, every strobe is ignored: no counter advances and `alarm` holds.
- R10: A change of `mode` clears `alarm` and all detector state. Mode 3 is idle and keeps `alarm` at 0.
- R11: `alarm` changes two clock edges after the edge that samples the deciding strobe. `alarm_chg` is 1 for exactly the cycles in which `alarm` has just changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Detection rule: 0 bit 2, 1 framing bit, 2 data link, 3 idle |
| in_sync | input | 1 | The framer is in frame alignment |
| ch_stb | input | 1 | Strobe for a channel bit-2 sample |
| ch_bit2 | input | 1 | Bit-2 value |
| fb_stb | input | 1 | Strobe for a framing bit |
| fb_idx | input | 4 | Frame index in the superframe, counted from 0 |
| fb_val | input | 1 | Framing-bit value |
| dl_stb | input | 1 | Strobe for a data-link bit |
| dl_bit | input | 1 | Data-link bit value |
| alarm | output | 1 | Remote alarm flag |
| alarm_chg | output | 1 | One-cycle pulse when `alarm` changes |

## Verification
Each detector registers its decision on the edge that samples the last strobe it needs, and the output stage registers that decision one edge later. The flag therefore moves two edges after that strobe. The bench drives inputs on falling edges. It checks after at least two further falling edges, and for R11 it checks the exact falling edge on which the flag and the pulse first show the change. A mode change reaches `alarm` one edge later, and the bench waits idle cycles before it compares anything.

// File: rtl/rai_pkg.sv
package rai_pkg;
  typedef enum logic [1:0] {
    RAI_SF_BIT2 = 2'd0,
    RAI_SF_FBIT = 2'd1,
    RAI_ESF_DL  = 2'd2,
    RAI_IDLE    = 2'd3
  } rai_mode_e;
endpackage

// File: rtl/rai_bit2_win.sv
module rai_bit2_win #(
  parameter int WIN    = 256,
  parameter int THRESH = 254
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  input  logic stb,
  input  logic bit2,
  output logic alarm_st
);
  localparam int CW = $clog2(WIN);
  localparam int ZW = $clog2(WIN + 1);

  logic [CW-1:0] pos;
  logic [ZW-1:0] zeros;
  logic          take;
  logic          last;
  logic [ZW-1:0] zeros_nx;

  assign take     = en && stb;
  assign last     = (pos == CW'(WIN - 1));
  assign zeros_nx = zeros + ZW'(!bit2);

  always_ff @(posedge clk) begin
    if (clr) begin
      pos      <= '0;
      zeros    <= '0;
      alarm_st <= 1'b0;
    end else if (take) begin
      if (last) begin
        alarm_st <= (zeros_nx >= ZW'(THRESH));
        zeros    <= '0;
        pos      <= '0;
      end else begin
        pos   <= pos + CW'(1);
        zeros <= zeros_nx;
      end
    end
  end

  // R3
  block_edge_chk: assert property (@(posedge clk) disable iff (clr)
    (!$stable(alarm_st) && !$past(clr)) |-> $past(take && last));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (!take) |=> $stable(alarm_st));
endmodule

// File: rtl/rai_fbit_pair.sv
module rai_fbit_pair #(
  parameter int IW   = 4,
  parameter int FIDX = 11
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          en,
  input  logic          stb,
  input  logic [IW-1:0] idx,
  input  logic          val,
  output logic          alarm_st
);
  logic hit;
  logic prev;
  logic have;

  assign hit = en && stb && (idx == IW'(FIDX));

  always_ff @(posedge clk) begin
    if (clr) begin
      prev     <= 1'b0;
      have     <= 1'b0;
      alarm_st <= 1'b0;
    end else if (hit) begin
      have <= 1'b1;
      prev <= val;
      if (have && (prev == val)) alarm_st <= val;
    end
  end

  // R4
  pair_set_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(alarm_st) |-> (prev && $past(prev) && $past(have)));

  // R5
  pair_clr_chk: assert property (@(posedge clk) disable iff (clr)
    ($fell(alarm_st) && !$past(clr)) |-> (!prev && !$past(prev)));

  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (!hit) |=> $stable(alarm_st));
endmodule

// File: rtl/rai_dl_pattern.sv
module rai_dl_pattern #(
  parameter int             SLOTW   = 16,
  parameter int             NSLOT   = 16,
  parameter int             CLR_MAX = 14,
  parameter logic [SLOTW-1:0] PAT   = 16'h00FF
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  input  logic stb,
  input  logic dbit,
  output logic alarm_st
);
  localparam int BW = $clog2(SLOTW);

  logic [SLOTW-1:0] sh;
  logic [BW-1:0]    bcnt;
  logic [NSLOT-1:0] hist;
  logic             take;
  logic             slot_end;
  logic [SLOTW-1:0] word;
  logic [NSLOT-1:0] hist_nx;
  int               hits;

  assign take     = en && stb;
  assign slot_end = take && (bcnt == BW'(SLOTW - 1));
  assign word     = {sh[SLOTW-2:0], dbit};
  assign hist_nx  = {hist[NSLOT-2:0], (word == PAT)};
  assign hits     = $countones(hist_nx);

  always_ff @(posedge clk) begin
    if (clr) begin
      sh       <= '0;
      bcnt     <= '0;
      hist     <= '0;
      alarm_st <= 1'b0;
    end else if (take) begin
      sh   <= word;
      bcnt <= slot_end ? '0 : bcnt + BW'(1);
      if (slot_end) begin
        hist <= hist_nx;
        if (hits == NSLOT)        alarm_st <= 1'b1;
        else if (hits <= CLR_MAX) alarm_st <= 1'b0;
      end
    end
  end

  // R7
  full_run_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(alarm_st) |-> ($countones(hist) == NSLOT));

  // R8
  drop_chk: assert property (@(posedge clk) disable iff (clr)
    ($fell(alarm_st) && !$past(clr)) |-> ($countones(hist) <= CLR_MAX));
endmodule

// File: rtl/t1_rai_detect.sv
module t1_rai_detect
  import rai_pkg::*;
#(
  parameter int               B2_WIN     = 256,
  parameter int               B2_THRESH  = 254,
  parameter int               FIDX_W     = 4,
  parameter int               FBIT_IDX   = 11,
  parameter int               DL_SLOT    = 16,
  parameter int               DL_NSLOT   = 16,
  parameter int               DL_CLR_MAX = 14,
  parameter logic [DL_SLOT-1:0] DL_PAT   = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              in_sync,
  input  logic              ch_stb,
  input  logic              ch_bit2,
  input  logic              fb_stb,
  input  logic [FIDX_W-1:0] fb_idx,
  input  logic              fb_val,
  input  logic              dl_stb,
  input  logic              dl_bit,
  output logic              alarm,
  output logic              alarm_chg
);
  rai_mode_e mode_q;
  logic      mode_chg;
  logic      clr;
  logic      st_b2, st_fb, st_dl;
  logic      sel;
  logic      alarm_nx;

  assign mode_chg = (mode != mode_q);
  assign clr      = rst || mode_chg;

  rai_bit2_win #(.WIN(B2_WIN), .THRESH(B2_THRESH)) u_b2 (
    .clk(clk), .clr(clr), .en(in_sync && (mode_q == RAI_SF_BIT2)),
    .stb(ch_stb), .bit2(ch_bit2), .alarm_st(st_b2));

  rai_fbit_pair #(.IW(FIDX_W), .FIDX(FBIT_IDX)) u_fb (
    .clk(clk), .clr(clr), .en(in_sync && (mode_q == RAI_SF_FBIT)),
    .stb(fb_stb), .idx(fb_idx), .val(fb_val), .alarm_st(st_fb));

  rai_dl_pattern #(.SLOTW(DL_SLOT), .NSLOT(DL_NSLOT), .CLR_MAX(DL_CLR_MAX), .PAT(DL_PAT)) u_dl (
    .clk(clk), .clr(clr), .en(in_sync && (mode_q == RAI_ESF_DL)),
    .stb(dl_stb), .dbit(dl_bit), .alarm_st(st_dl));

  always_comb begin
    case (mode_q)
      RAI_SF_BIT2: sel = st_b2;
      RAI_SF_FBIT: sel = st_fb;
      RAI_ESF_DL:  sel = st_dl;
      default:     sel = 1'b0;
    endcase
  end

  assign alarm_nx = mode_chg ? 1'b0 : sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= rai_mode_e'(mode);
      alarm     <= 1'b0;
      alarm_chg <= 1'b0;
    end else begin
      mode_q    <= rai_mode_e'(mode);
      alarm     <= alarm_nx;
      alarm_chg <= (alarm_nx != alarm);
    end
  end

  // R11
  chg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_chg |-> (alarm != $past(alarm)));

  // R10
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !alarm);

  // R10
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == RAI_IDLE) && !mode_chg) |=> !alarm);
endmodule

// File: tb/sim_t1_rai_detect.sv
module sim_t1_rai_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       in_sync = 1'b1;
  logic       ch_stb = 1'b0, ch_bit2 = 1'b0;
  logic       fb_stb = 1'b0, fb_val = 1'b0;
  logic [3:0] fb_idx = 4'd0;
  logic       dl_stb = 1'b0, dl_bit = 1'b0;
  logic       alarm, alarm_chg;

  int checks = 0;
  int bad = 0;
  int chg_bad = 0;
  int chg_seen = 0;
  logic prev_alarm = 1'b0;

  logic exp_alarm = 1'b0;
  logic m_prev = 1'b0, m_have = 1'b0;
  logic [15:0] m_hist = '0;

  always #2.5 clk = ~clk;

  t1_rai_detect u0 (
    .clk(clk), .rst(rst), .mode(mode), .in_sync(in_sync),
    .ch_stb(ch_stb), .ch_bit2(ch_bit2), .fb_stb(fb_stb), .fb_idx(fb_idx),
    .fb_val(fb_val), .dl_stb(dl_stb), .dl_bit(dl_bit),
    .alarm(alarm), .alarm_chg(alarm_chg));

  // R11 pulse monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (alarm_chg !== (alarm != prev_alarm)) chg_bad++;
      if (alarm_chg) chg_seen++;
    end
    prev_alarm = alarm;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int ones16(input logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic model_clear();
    exp_alarm = 1'b0; m_prev = 1'b0; m_have = 1'b0; m_hist = '0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode = m;
    model_clear();
    idle(3);
  endtask

  task automatic ch(input logic b);
    ch_stb = 1'b1; ch_bit2 = b;
    @(negedge clk);
    ch_stb = 1'b0;
  endtask

  // full block with nz zeros scattered by an odd-stride permutation
  task automatic block(input int nz, input int off);
    for (int i = 0; i < 256; i++) ch((((i * 37) + off) % 256) >= nz);
    if (in_sync) exp_alarm = (nz >= 254);
  endtask

  task automatic fb(input logic [3:0] idx, input logic v);
    fb_stb = 1'b1; fb_idx = idx; fb_val = v;
    @(negedge clk);
    fb_stb = 1'b0;
    if (in_sync && idx == 4'd11) begin
      if (m_have && m_prev == v) exp_alarm = v;
      m_prev = v; m_have = 1'b1;
    end
  endtask

  task automatic dl_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      dl_stb = 1'b1; dl_bit = w[i];
      @(negedge clk);
    end
    dl_stb = 1'b0;
    m_hist = {m_hist[14:0], (w == 16'h00FF)};
    if (m_hist == 16'hFFFF) exp_alarm = 1'b1;
    else if (ones16(m_hist) <= 14) exp_alarm = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    idle(4);
    chk("R1 alarm", alarm, 1'b0);
    chk("R1 alarm_chg", alarm_chg, 1'b0);
    rst = 1'b0;
    idle(2);

    // bit-2 mode
    block(253, 5); idle(3); chk("R3 253 zeros", alarm, 1'b0);
    for (int i = 0; i < 255; i++) ch(1'b0);
    idle(3); chk("R3 no change mid-block", alarm, 1'b0);
    ch(1'b1); exp_alarm = 1'b1; idle(3); chk("R2 255 zeros", alarm, 1'b1);
    block(254, 9); idle(3); chk("R2 254 zeros", alarm, exp_alarm);
    block(253, 3); idle(3); chk("R3 clears at 253", alarm, 1'b0);
    for (int k = 0; k < 6; k++) begin
      block(250 + int'($urandom % 7), int'($urandom % 256));
      idle(3); chk("R2 random block", alarm, exp_alarm);
    end
    block(256, 0); idle(3); chk("R2 all zeros", alarm, 1'b1);
    in_sync = 1'b0;
    block(0, 0); idle(3); chk("R9 out of sync ignored", alarm, 1'b1);
    in_sync = 1'b1;
    for (int i = 0; i < 100; i++) ch(1'b0);
    set_mode(2'd1); chk("R10 mode change clears", alarm, 1'b0);
    set_mode(2'd0);
    for (int i = 0; i < 255; i++) ch(1'b0);
    idle(3); chk("R10 counters cleared", alarm, 1'b0);
    ch(1'b0); idle(3); chk("R2 after clear", alarm, 1'b1);

    // framing-bit mode
    set_mode(2'd1);
    fb(4'd11, 1'b1); idle(3); chk("R4 single one", alarm, 1'b0);
    fb(4'd11, 1'b1);
    chk("R11 not yet", alarm, 1'b0);
    @(negedge clk);
    chk("R11 alarm on time", alarm, 1'b1);
    chk("R11 pulse", alarm_chg, 1'b1);
    @(negedge clk);
    chk("R11 pulse one cycle", alarm_chg, 1'b0);
    fb(4'd11, 1'b0); idle(3); chk("R5 single zero", alarm, 1'b1);
    fb(4'd3, 1'b0); idle(3); chk("R6 other index", alarm, 1'b1);
    fb(4'd11, 1'b1); fb(4'd11, 1'b0); idle(3); chk("R5 alternating", alarm, 1'b1);
    fb(4'd11, 1'b0); idle(3); chk("R5 two zeros", alarm, 1'b0);
    for (int k = 0; k < 40; k++) begin
      fb(($urandom % 2) ? 4'd11 : 4'($urandom % 12), 1'($urandom % 2));
      idle(2); chk("R6 random framing", alarm, exp_alarm);
    end

    // data-link mode
    set_mode(2'd2);
    for (int k = 0; k < 16; k++) dl_word(16'hFF00);
    idle(3); chk("R7 reversed word", alarm, 1'b0);
    for (int k = 0; k < 15; k++) dl_word(16'h00FF);
    idle(3); chk("R7 fifteen", alarm, 1'b0);
    dl_word(16'h00FF); idle(3); chk("R7 sixteen", alarm, 1'b1);
    dl_word(16'h01FF); idle(3); chk("R8 fifteen of sixteen", alarm, 1'b1);
    dl_word(16'h00FE); idle(3); chk("R8 fourteen", alarm, 1'b0);
    for (int k = 0; k < 50; k++) begin
      dl_word(($urandom % 8 != 0) ? 16'h00FF : (16'h00FF ^ (16'd1 << ($urandom % 16))));
      idle(2); chk("R8 random data link", alarm, exp_alarm);
    end
    for (int k = 0; k < 16; k++) dl_word(16'h00FF);
    idle(3); chk("R7 rerun", alarm, 1'b1);

    // idle mode
    set_mode(2'd3); chk("R10 idle mode", alarm, 1'b0);
    for (int k = 0; k < 16; k++) dl_word(16'h00FF);
    fb(4'd11, 1'b1); fb(4'd11, 1'b1);
    idle(3); chk("R10 idle ignores strobes", alarm, 1'b0);

    checks++;
    if (chg_bad != 0 || chg_seen == 0) begin
      bad++;
      $display("FAIL R11 pulse mismatches actual=%0d expected=0 (pulses=%0d)", chg_bad, chg_seen);
    end
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule